// File: doc/BRIEF.md
# Node Slot Phase Scheduler

This block keeps a small array of node slots. Software fills each slot through a register write port. A slot holds a start address, a neighbour count, a precision flag and an aggregation function code. Once armed, the slot passes through three phases in a fixed order: it requests a fetch from a prefetch engine, then a reduction from an aggregation engine, and then a transformation from a transform engine. Each engine has its own valid/ready request channel and a response pulse that names the slot.

A fetch can come back complete or partial. A partial slot may start its aggregation. It may not leave aggregation until the prefetcher reports, in a later update, that the full neighbour count has been fetched. A transformation request is held back until two things are true: the slot's aggregation result has arrived, and the number of results waiting in the aggregation buffer has reached a programmable threshold. When several slots compete for one channel, a round-robin arbiter grants one slot per cycle.

Top module: `nodeslot_sched`

## Requirements
- R1: After reset every slot reads IDLE, the error flag is 0 and no request channel is valid. Slot state codes are IDLE=0, PROGRAMMED=1, PREFETCH=2, AGGREGATION=3, TRANSFORMATION=4 and DONE=5. Slot s occupies bits [3s+2:3s] of `slot_state_o`.
- R2: A write to slot s uses `cfg_wr_addr` = {1'b0, s, reg}. Register 0 holds the start address and register 1 holds the neighbour count. Register 2 holds the precision in bit 0 and the function code in bits 2:1. Register 3 is a command: bit 0 arms the slot and bit 1 clears it. Arming an IDLE slot makes it PROGRAMMED at the next edge.
- R3: A prefetch request is valid only for a PROGRAMMED slot, and an aggregation request only for a slot in AGGREGATION. A slot issues no aggregation request while in PREFETCH. A prefetch handshake moves the slot to PREFETCH.
- R4: The address, count, precision and function carried in each request equal the values programmed for that slot.
- R5: Response codes are 0=OK, 1=PARTIAL and 2=UPDATE. OK or PARTIAL moves a PREFETCH slot to AGGREGATION. A PARTIAL slot stays in AGGREGATION until an UPDATE for it arrives. An UPDATE for a slot with no partial fetch pending has no effect.
- R6: Once a slot's aggregation response has arrived and it has no partial fetch pending, it enters TRANSFORMATION one edge later. No transformation request is ever issued for a slot without an aggregation response.
- R7: The buffer count rises by one on each aggregation response and falls by one on each transformation response. A slot in TRANSFORMATION raises a new transformation request only when this count is at least the threshold. The threshold is written through `cfg_wr_addr` = {1'b1, 0...0}.
- R8: Each channel grants one slot per handshake. The search starts at the slot after the one last granted on that channel. After reset the first candidate is slot 0.
- R9: A request that is valid while ready is low keeps its valid and its slot unchanged until the handshake.
- R10: A write to a slot that is not IDLE is ignored and sets a sticky error flag. The one exception is a clear command to a DONE slot, which returns that slot to IDLE without error.
- R11: A transformation response for a slot whose request was accepted moves it to DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | SLOT_W+3 | Register write address |
| cfg_wr_data | input | DATA_W | Register write data |
| pf_req_valid | output | 1 | Prefetch request valid |
| pf_req_ready | input | 1 | Prefetch request ready |
| pf_req_slot | output | SLOT_W | Prefetch request slot |
| pf_req_addr | output | ADDR_W | Prefetch start address |
| pf_req_count | output | CNT_W | Prefetch neighbour count |
| pf_req_prec | output | 1 | Prefetch precision |
| pf_rsp_valid | input | 1 | Prefetch response pulse |
| pf_rsp_slot | input | SLOT_W | Prefetch response slot |
| pf_rsp_code | input | 2 | Prefetch response code |
| ag_req_valid | output | 1 | Aggregation request valid |
| ag_req_ready | input | 1 | Aggregation request ready |
| ag_req_slot | output | SLOT_W | Aggregation request slot |
| ag_req_addr | output | ADDR_W | Aggregation start address |
| ag_req_count | output | CNT_W | Aggregation neighbour count |
| ag_req_prec | output | 1 | Aggregation precision |
| ag_req_func | output | 2 | Aggregation function code |
| ag_rsp_valid | input | 1 | Aggregation response pulse |
| ag_rsp_slot | input | SLOT_W | Aggregation response slot |
| tr_req_valid | output | 1 | Transformation request valid |
| tr_req_ready | input | 1 | Transformation request ready |
| tr_req_slot | output | SLOT_W | Transformation request slot |
| tr_req_count | output | CNT_W | Transformation neighbour count |
| tr_req_prec | output | 1 | Transformation precision |
| tr_rsp_valid | input | 1 | Transformation response pulse |
| tr_rsp_slot | input | SLOT_W | Transformation response slot |
| slot_state_o | output | 3*NSLOT | Packed per-slot state codes |
| cfg_err_o | output | 1 | Sticky illegal-write flag |

## Verification
A register write or a response pulse takes effect at the edge that samples it. A state that permits a request makes the request valid in the same cycle, so the handshake falls on the edge after that. When an aggregation response completes a slot, TRANSFORMATION follows one further edge later. The transformation request can then complete on the edge after that. The bench drives inputs at falling edges and records handshakes at rising edges. It waits a fixed idle window of at least one spare cycle beyond these latencies before comparing states, grant orders and the error flag against values it derives from its own copy of the programmed slot contents and its own buffer count.

// File: rtl/nodeslot_sched.sv
module nodeslot_sched #(
  parameter int NSLOT  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int BCNT_W = $clog2(NSLOT + 1),
  localparam int CFG_AW = SLOT_W + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic [CFG_AW-1:0]     cfg_wr_addr,
  input  logic [DATA_W-1:0]     cfg_wr_data,
  output logic                  pf_req_valid,
  input  logic                  pf_req_ready,
  output logic [SLOT_W-1:0]     pf_req_slot,
  output logic [ADDR_W-1:0]     pf_req_addr,
  output logic [CNT_W-1:0]      pf_req_count,
  output logic                  pf_req_prec,
  input  logic                  pf_rsp_valid,
  input  logic [SLOT_W-1:0]     pf_rsp_slot,
  input  logic [1:0]            pf_rsp_code,
  output logic                  ag_req_valid,
  input  logic                  ag_req_ready,
  output logic [SLOT_W-1:0]     ag_req_slot,
  output logic [ADDR_W-1:0]     ag_req_addr,
  output logic [CNT_W-1:0]      ag_req_count,
  output logic                  ag_req_prec,
  output logic [1:0]            ag_req_func,
  input  logic                  ag_rsp_valid,
  input  logic [SLOT_W-1:0]     ag_rsp_slot,
  output logic                  tr_req_valid,
  input  logic                  tr_req_ready,
  output logic [SLOT_W-1:0]     tr_req_slot,
  output logic [CNT_W-1:0]      tr_req_count,
  output logic                  tr_req_prec,
  input  logic                  tr_rsp_valid,
  input  logic [SLOT_W-1:0]     tr_rsp_slot,
  output logic [3*NSLOT-1:0]    slot_state_o,
  output logic                  cfg_err_o
);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_PROG = 3'd1;
  localparam logic [2:0] S_PREF = 3'd2;
  localparam logic [2:0] S_AGGR = 3'd3;
  localparam logic [2:0] S_XFRM = 3'd4;
  localparam logic [2:0] S_DONE = 3'd5;

  localparam logic [1:0] RC_OK   = 2'd0;
  localparam logic [1:0] RC_PART = 2'd1;
  localparam logic [1:0] RC_UPD  = 2'd2;

  logic [NSLOT-1:0][2:0]        st_q;
  logic [NSLOT-1:0][ADDR_W-1:0] addr_q;
  logic [NSLOT-1:0][CNT_W-1:0]  cnt_q;
  logic [NSLOT-1:0][1:0]        func_q;
  logic [NSLOT-1:0]             prec_q, part_q, agi_q, agd_q, tri_q;
  logic [BCNT_W-1:0]            thr_q, buf_q;
  logic                         err_q;

  logic [2:0][NSLOT-1:0]        rq;
  logic [2:0][SLOT_W:0]         pick;
  logic [2:0][SLOT_W-1:0]       sel, last_q, hold_q;
  logic [2:0]                   vld, rdy, hs, lock_q;

  logic [NSLOT-1:0]             hit, clr_ok, bad;
  logic                         wr_glob;
  logic [SLOT_W-1:0]            wr_slot;
  logic [1:0]                   wr_reg;

  function automatic logic [SLOT_W:0] rr_pick(input logic [NSLOT-1:0] req,
                                              input logic [SLOT_W-1:0] last);
    logic [SLOT_W:0] r;
    r = '0;
    for (int k = NSLOT; k >= 1; k--) begin
      int idx;
      idx = (int'(last) + k) % NSLOT;
      if (req[idx]) r = {1'b1, SLOT_W'(idx)};
    end
    return r;
  endfunction

  assign wr_glob = cfg_wr_en & cfg_wr_addr[CFG_AW-1];
  assign wr_slot = cfg_wr_addr[SLOT_W+1:2];
  assign wr_reg  = cfg_wr_addr[1:0];

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      hit[i]    = cfg_wr_en && !cfg_wr_addr[CFG_AW-1] && (wr_slot == SLOT_W'(i));
      clr_ok[i] = hit[i] && (wr_reg == 2'd3) && cfg_wr_data[1] && (st_q[i] == S_DONE);
      bad[i]    = hit[i] && (st_q[i] != S_IDLE) && !clr_ok[i];
      rq[0][i]  = (st_q[i] == S_PROG);
      rq[1][i]  = (st_q[i] == S_AGGR) && !agi_q[i];
      rq[2][i]  = (st_q[i] == S_XFRM) && !tri_q[i] && (buf_q >= thr_q);
    end
  end

  assign rdy = {tr_req_ready, ag_req_ready, pf_req_ready};

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      pick[c] = rr_pick(rq[c], last_q[c]);
      vld[c]  = lock_q[c] | pick[c][SLOT_W];
      sel[c]  = lock_q[c] ? hold_q[c] : pick[c][SLOT_W-1:0];
    end
  end

  assign hs = vld & rdy;

  always_ff @(posedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (!rst_n) begin
        lock_q[c] <= 1'b0;
        last_q[c] <= SLOT_W'(NSLOT - 1);
        hold_q[c] <= '0;
      end else if (hs[c]) begin
        lock_q[c] <= 1'b0;
        last_q[c] <= sel[c];
      end else if (vld[c]) begin
        lock_q[c] <= 1'b1;
        hold_q[c] <= sel[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (!rst_n) begin
        st_q[i]   <= S_IDLE;
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        func_q[i] <= '0;
        prec_q[i] <= 1'b0;
        part_q[i] <= 1'b0;
        agi_q[i]  <= 1'b0;
        agd_q[i]  <= 1'b0;
        tri_q[i]  <= 1'b0;
      end else begin
        case (st_q[i])
          S_IDLE: if (hit[i]) begin
            case (wr_reg)
              2'd0: addr_q[i] <= cfg_wr_data[ADDR_W-1:0];
              2'd1: cnt_q[i]  <= cfg_wr_data[CNT_W-1:0];
              2'd2: begin
                prec_q[i] <= cfg_wr_data[0];
                func_q[i] <= cfg_wr_data[2:1];
              end
              default: if (cfg_wr_data[0]) begin
                st_q[i]   <= S_PROG;
                part_q[i] <= 1'b0;
                agi_q[i]  <= 1'b0;
                agd_q[i]  <= 1'b0;
                tri_q[i]  <= 1'b0;
              end
            endcase
          end
          S_PROG: if (hs[0] && sel[0] == SLOT_W'(i)) st_q[i] <= S_PREF;
          S_PREF: if (pf_rsp_valid && pf_rsp_slot == SLOT_W'(i)) begin
            if (pf_rsp_code == RC_OK) st_q[i] <= S_AGGR;
            else if (pf_rsp_code == RC_PART) begin
              st_q[i]   <= S_AGGR;
              part_q[i] <= 1'b1;
            end
          end
          S_AGGR: begin
            if (hs[1] && sel[1] == SLOT_W'(i)) agi_q[i] <= 1'b1;
            if (ag_rsp_valid && ag_rsp_slot == SLOT_W'(i) && agi_q[i]) agd_q[i] <= 1'b1;
            if (pf_rsp_valid && pf_rsp_slot == SLOT_W'(i) && pf_rsp_code == RC_UPD)
              part_q[i] <= 1'b0;
            if (agd_q[i] && !part_q[i]) st_q[i] <= S_XFRM;
          end
          S_XFRM: begin
            if (hs[2] && sel[2] == SLOT_W'(i)) tri_q[i] <= 1'b1;
            if (tr_rsp_valid && tr_rsp_slot == SLOT_W'(i) && tri_q[i]) st_q[i] <= S_DONE;
          end
          S_DONE: if (clr_ok[i]) st_q[i] <= S_IDLE;
          default: st_q[i] <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
      buf_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= err_q | (|bad);
      if (wr_glob && wr_reg == 2'd0) thr_q <= cfg_wr_data[BCNT_W-1:0];
      if (ag_rsp_valid && !tr_rsp_valid && buf_q != BCNT_W'(NSLOT))
        buf_q <= buf_q + 1'b1;
      else if (tr_rsp_valid && !ag_rsp_valid && buf_q != '0)
        buf_q <= buf_q - 1'b1;
    end
  end

  assign pf_req_valid = vld[0];
  assign pf_req_slot  = sel[0];
  assign pf_req_addr  = addr_q[sel[0]];
  assign pf_req_count = cnt_q[sel[0]];
  assign pf_req_prec  = prec_q[sel[0]];

  assign ag_req_valid = vld[1];
  assign ag_req_slot  = sel[1];
  assign ag_req_addr  = addr_q[sel[1]];
  assign ag_req_count = cnt_q[sel[1]];
  assign ag_req_prec  = prec_q[sel[1]];
  assign ag_req_func  = func_q[sel[1]];

  assign tr_req_valid = vld[2];
  assign tr_req_slot  = sel[2];
  assign tr_req_count = cnt_q[sel[2]];
  assign tr_req_prec  = prec_q[sel[2]];

  assign slot_state_o = st_q;
  assign cfg_err_o    = err_q;

endmodule

// File: rtl/nodeslot_sched_chk.sv
module nodeslot_sched_chk #(
  parameter int NSLOT = 4,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int BCNT_W = $clog2(NSLOT + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pf_req_valid,
  input logic               pf_req_ready,
  input logic [SLOT_W-1:0]  pf_req_slot,
  input logic               ag_req_valid,
  input logic               ag_req_ready,
  input logic [SLOT_W-1:0]  ag_req_slot,
  input logic               tr_req_valid,
  input logic               tr_req_ready,
  input logic [SLOT_W-1:0]  tr_req_slot,
  input logic [3*NSLOT-1:0] slot_state_o,
  input logic               cfg_err_o,
  input logic [BCNT_W-1:0]  buf_q,
  input logic [BCNT_W-1:0]  thr_q
);

  p_pf_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_valid |-> slot_state_o[pf_req_slot*3 +: 3] == 3'd1);

  p_ag_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ag_req_valid |-> slot_state_o[ag_req_slot*3 +: 3] == 3'd3);

  p_tr_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tr_req_valid |-> slot_state_o[tr_req_slot*3 +: 3] == 3'd4);

  p_tr_thresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_req_valid && !($past(tr_req_valid) && !$past(tr_req_ready))) |-> buf_q >= thr_q);

  p_pf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req_valid && !pf_req_ready) |=> (pf_req_valid && $stable(pf_req_slot)));

  p_ag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_req_valid && !ag_req_ready) |=> (ag_req_valid && $stable(ag_req_slot)));

  p_tr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_req_valid && !tr_req_ready) |=> (tr_req_valid && $stable(tr_req_slot)));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);

endmodule

bind nodeslot_sched nodeslot_sched_chk #(.NSLOT(NSLOT)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pf_req_valid (pf_req_valid),
  .pf_req_ready (pf_req_ready),
  .pf_req_slot  (pf_req_slot),
  .ag_req_valid (ag_req_valid),
  .ag_req_ready (ag_req_ready),
  .ag_req_slot  (ag_req_slot),
  .tr_req_valid (tr_req_valid),
  .tr_req_ready (tr_req_ready),
  .tr_req_slot  (tr_req_slot),
  .slot_state_o (slot_state_o),
  .cfg_err_o    (cfg_err_o),
  .buf_q        (buf_q),
  .thr_q        (thr_q)
);

// File: tb/nodeslot_sched_tb.sv
module nodeslot_sched_tb_top;
  localparam int NS = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [SW+2:0] cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic pf_req_valid, pf_req_ready, pf_req_prec;
  logic [SW-1:0] pf_req_slot;
  logic [31:0] pf_req_addr;
  logic [15:0] pf_req_count;
  logic pf_rsp_valid = 1'b0;
  logic [SW-1:0] pf_rsp_slot = '0;
  logic [1:0] pf_rsp_code = '0;
  logic ag_req_valid, ag_req_ready, ag_req_prec;
  logic [SW-1:0] ag_req_slot;
  logic [31:0] ag_req_addr;
  logic [15:0] ag_req_count;
  logic [1:0] ag_req_func;
  logic ag_rsp_valid = 1'b0;
  logic [SW-1:0] ag_rsp_slot = '0;
  logic tr_req_valid, tr_req_ready, tr_req_prec;
  logic [SW-1:0] tr_req_slot;
  logic [15:0] tr_req_count;
  logic tr_rsp_valid = 1'b0;
  logic [SW-1:0] tr_rsp_slot = '0;
  logic [3*NS-1:0] slot_state_o;
  logic cfg_err_o;

  always #5 clk = ~clk;

  nodeslot_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready), .pf_req_slot(pf_req_slot),
    .pf_req_addr(pf_req_addr), .pf_req_count(pf_req_count), .pf_req_prec(pf_req_prec),
    .pf_rsp_valid(pf_rsp_valid), .pf_rsp_slot(pf_rsp_slot), .pf_rsp_code(pf_rsp_code),
    .ag_req_valid(ag_req_valid), .ag_req_ready(ag_req_ready), .ag_req_slot(ag_req_slot),
    .ag_req_addr(ag_req_addr), .ag_req_count(ag_req_count), .ag_req_prec(ag_req_prec),
    .ag_req_func(ag_req_func), .ag_rsp_valid(ag_rsp_valid), .ag_rsp_slot(ag_rsp_slot),
    .tr_req_valid(tr_req_valid), .tr_req_ready(tr_req_ready), .tr_req_slot(tr_req_slot),
    .tr_req_count(tr_req_count), .tr_req_prec(tr_req_prec),
    .tr_rsp_valid(tr_rsp_valid), .tr_rsp_slot(tr_rsp_slot),
    .slot_state_o(slot_state_o), .cfg_err_o(cfg_err_o)
  );

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] exp_addr [NS];
  logic [15:0] exp_cnt [NS];
  logic exp_prec [NS];
  logic [1:0] exp_func [NS];
  logic ag_seen [NS];
  int tb_buf = 0;
  int pf_log [16];
  int ag_log [16];
  int tr_log [16];
  logic [31:0] pf_addr_log [16];
  int pf_n = 0, ag_n = 0, tr_n = 0;
  logic pf_rdy = 1'b1, ag_rdy = 1'b0, tr_rdy = 1'b1;

  assign pf_req_ready = pf_rdy;
  assign ag_req_ready = ag_rdy;
  assign tr_req_ready = tr_rdy;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int st(input int s);
    return int'(slot_state_o[3*s +: 3]);
  endfunction

  always @(posedge clk) if (rst_n) begin
    if (pf_req_valid && pf_req_ready) begin
      pf_log[pf_n] = int'(pf_req_slot);
      pf_addr_log[pf_n] = pf_req_addr;
      pf_n++;
      chk(pf_req_addr == exp_addr[pf_req_slot], "R4", "pf addr", int'(pf_req_addr), int'(exp_addr[pf_req_slot]));
      chk(pf_req_count == exp_cnt[pf_req_slot], "R4", "pf count", int'(pf_req_count), int'(exp_cnt[pf_req_slot]));
      chk(pf_req_prec == exp_prec[pf_req_slot], "R4", "pf prec", int'(pf_req_prec), int'(exp_prec[pf_req_slot]));
    end
    if (ag_req_valid && ag_req_ready) begin
      ag_log[ag_n] = int'(ag_req_slot);
      ag_n++;
      chk(ag_req_addr == exp_addr[ag_req_slot], "R4", "ag addr", int'(ag_req_addr), int'(exp_addr[ag_req_slot]));
      chk(ag_req_count == exp_cnt[ag_req_slot], "R4", "ag count", int'(ag_req_count), int'(exp_cnt[ag_req_slot]));
      chk(ag_req_func == exp_func[ag_req_slot], "R4", "ag func", int'(ag_req_func), int'(exp_func[ag_req_slot]));
      chk(ag_req_prec == exp_prec[ag_req_slot], "R4", "ag prec", int'(ag_req_prec), int'(exp_prec[ag_req_slot]));
    end
    if (tr_req_valid && tr_req_ready) begin
      tr_log[tr_n] = int'(tr_req_slot);
      tr_n++;
      chk(tr_req_count == exp_cnt[tr_req_slot], "R4", "tr count", int'(tr_req_count), int'(exp_cnt[tr_req_slot]));
      chk(tr_req_prec == exp_prec[tr_req_slot], "R4", "tr prec", int'(tr_req_prec), int'(exp_prec[tr_req_slot]));
      chk(ag_seen[tr_req_slot], "R6", "tr after ag response", 0, 1);
      chk(tb_buf >= 2, "R7", "buffer count at tr grant", tb_buf, 2);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = (SW+3)'(a); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic pf_rsp(input int s, input logic [1:0] code);
    @(negedge clk);
    pf_rsp_valid = 1'b1; pf_rsp_slot = SW'(s); pf_rsp_code = code;
    @(negedge clk);
    pf_rsp_valid = 1'b0;
  endtask

  task automatic ag_rsp(input int s);
    @(negedge clk);
    ag_rsp_valid = 1'b1; ag_rsp_slot = SW'(s);
    ag_seen[s] = 1'b1; tb_buf++;
    @(negedge clk);
    ag_rsp_valid = 1'b0;
  endtask

  task automatic tr_rsp(input int s);
    @(negedge clk);
    tr_rsp_valid = 1'b1; tr_rsp_slot = SW'(s);
    tb_buf--;
    @(negedge clk);
    tr_rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) ag_seen[s] = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    for (int s = 0; s < NS; s++) chk(st(s) == 0, "R1", "reset state", st(s), 0);
    chk(cfg_err_o == 1'b0, "R1", "reset err", int'(cfg_err_o), 0);
    chk(!pf_req_valid && !ag_req_valid && !tr_req_valid, "R1", "reset valids", 1, 0);

    wr(1 << (SW+2), 32'd2);
    for (int s = 0; s < NS; s++) begin
      exp_addr[s] = 32'h1000 * (s + 1) + 32'(s * 4);
      exp_cnt[s]  = 16'(5 + 3 * s);
      exp_prec[s] = s[0];
      exp_func[s] = 2'(s % 3);
      wr(s*4 + 0, exp_addr[s]);
      wr(s*4 + 1, 32'(exp_cnt[s]));
      wr(s*4 + 2, {29'd0, exp_func[s], exp_prec[s]});
    end
    for (int s = 0; s < NS; s++) chk(st(s) == 0, "R2", "unarmed stays IDLE", st(s), 0);
    wr(0*4 + 3, 32'd1);
    chk(st(0) == 1 || st(0) == 2, "R2", "arm leaves IDLE", st(0), 1);
    for (int s = 1; s < NS; s++) wr(s*4 + 3, 32'd1);
    idle(3);
    chk(pf_n == 4, "R3", "prefetch grants", pf_n, 4);
    for (int k = 0; k < 4; k++) chk(pf_log[k] == k, "R8", "pf grant order", pf_log[k], k);
    for (int s = 0; s < NS; s++) chk(st(s) == 2, "R3", "state PREFETCH", st(s), 2);
    chk(ag_req_valid == 1'b0, "R3", "no ag request in PREFETCH", int'(ag_req_valid), 0);

    pf_rsp(2, 2'd0); idle(1);
    pf_rsp(0, 2'd0); idle(1);
    pf_rsp(3, 2'd1); idle(1);
    pf_rsp(1, 2'd1); idle(1);
    for (int s = 0; s < NS; s++) chk(st(s) == 3, "R5", "state AGGREGATION", st(s), 3);
    chk(ag_req_valid && ag_req_slot == 2'd2, "R9", "stalled ag request held", int'(ag_req_slot), 2);
    idle(2);
    chk(ag_req_valid && ag_req_slot == 2'd2, "R9", "ag request still held", int'(ag_req_slot), 2);
    ag_rdy = 1'b1;
    idle(6);
    chk(ag_n == 4, "R3", "aggregation grants", ag_n, 4);
    chk(ag_log[0] == 2, "R8", "ag order 0", ag_log[0], 2);
    chk(ag_log[1] == 3, "R8", "ag order 1", ag_log[1], 3);
    chk(ag_log[2] == 0, "R8", "ag order 2", ag_log[2], 0);
    chk(ag_log[3] == 1, "R8", "ag order 3", ag_log[3], 1);

    ag_rsp(0); idle(3);
    chk(st(0) == 4, "R6", "slot0 TRANSFORMATION", st(0), 4);
    chk(tr_req_valid == 1'b0, "R7", "below threshold no tr", int'(tr_req_valid), 0);
    chk(tr_n == 0, "R7", "no tr grants yet", tr_n, 0);
    ag_rsp(1); idle(3);
    chk(st(1) == 3, "R5", "partial slot1 held", st(1), 3);
    chk(tr_n == 1 && tr_log[0] == 0, "R7", "threshold reached slot0 tr", tr_n, 1);
    pf_rsp(2, 2'd2);
    ag_rsp(3); idle(3);
    chk(st(3) == 3, "R5", "partial slot3 held", st(3), 3);
    chk(st(2) == 3, "R5", "update to non-partial slot ignored", st(2), 3);
    pf_rsp(1, 2'd2); idle(4);
    chk(st(1) == 4, "R5", "update releases slot1", st(1), 4);
    chk(tr_n == 2 && tr_log[1] == 1, "R6", "slot1 tr issued", tr_n, 2);
    tr_rsp(0); idle(2);
    chk(st(0) == 5, "R11", "slot0 DONE", st(0), 5);

    chk(cfg_err_o == 1'b0, "R10", "no error yet", int'(cfg_err_o), 0);
    wr(0*4 + 0, 32'hDEAD0000); idle(1);
    chk(cfg_err_o == 1'b1, "R10", "write to DONE slot flags", int'(cfg_err_o), 1);
    chk(st(0) == 5, "R10", "slot0 still DONE", st(0), 5);
    wr(2*4 + 3, 32'd1); idle(1);
    chk(st(2) == 3, "R10", "arm of busy slot ignored", st(2), 3);
    wr(0*4 + 3, 32'd2); idle(1);
    chk(st(0) == 0, "R10", "clear DONE slot", st(0), 0);
    chk(cfg_err_o == 1'b1, "R10", "error sticky", int'(cfg_err_o), 1);
    wr(0*4 + 3, 32'd1); idle(3);
    chk(pf_n == 5 && pf_log[4] == 0, "R2", "re-armed slot0 prefetch", pf_n, 5);
    chk(pf_addr_log[4] == exp_addr[0], "R10", "ignored write left address", int'(pf_addr_log[4]), int'(exp_addr[0]));
    chk(st(0) == 2, "R3", "slot0 PREFETCH again", st(0), 2);

    ag_rsp(2); idle(4);
    chk(st(2) == 4 && tr_n == 3, "R6", "slot2 tr issued", tr_n, 3);
    pf_rsp(3, 2'd2); idle(4);
    chk(tr_n == 4 && tr_log[3] == 3, "R5", "slot3 tr after update", tr_n, 4);
    tr_rsp(1); tr_rsp(2); tr_rsp(3); idle(2);
    for (int s = 1; s < NS; s++) chk(st(s) == 5, "R11", "slot DONE", st(s), 5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule